// File: doc/BRIEF.md
# Transmit Auto-Pad and Frame Check Sequence Inserter

This block sits in the transmit byte stream of an Ethernet MAC. Frame bytes arrive one per beat on a valid/ready interface, and the final byte is marked by a last flag. The block forwards each byte unchanged. If a frame is shorter than the minimum and padding is enabled, it appends zero bytes. It can then append the four-byte CRC-32 frame check sequence, which is computed over every byte it sent, pad bytes included.

The two control pins `pad_en` and `fcs_dis` are plain levels and must stay steady for the length of a frame. The per-frame request `in_add_fcs` is sampled on the beat that carries `in_last`. Back-pressure has a single source: `out_ready`. While the block is forwarding input bytes, `in_ready` equals `out_ready`. While it generates pad or FCS bytes, `in_ready` is low. A byte offered on the output holds steady until it is accepted.

Top module: `tx_pad_fcs`

## Requirements
- R1: While the block is forwarding input bytes, it passes each one unchanged and in order, and `in_ready` equals `out_ready`. `in_ready` is never high while `out_ready` is low.
- R2: With `pad_en` high, a frame with fewer than 60 input bytes is extended with bytes of value 0x00 until 60 bytes have been sent. The input stream is not accepted while the pad is sent.
- R3: A frame with 60 or more input bytes receives no pad, whatever the state of `pad_en`.
- R4: The FCS is CRC-32 with polynomial 0x04C11DB7, bit-reflected, preset to all ones and complemented at the end. It covers the input bytes and the pad bytes. It follows the last pad byte and is sent least significant byte first.
- R5: A frame that received pad always gets an FCS, even when `fcs_dis` is high and `in_add_fcs` is low.
- R6: A frame without pad gets an FCS only when `in_add_fcs` is high on its last beat and `fcs_dis` is low. Otherwise its output ends on its own last byte.
- R7: With `pad_en` low, a short frame leaves at its own length.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold. No byte is lost or repeated.
- R9: `out_last` is high only on the final byte of each output frame. That byte is the last FCS byte, or the last input byte when no FCS is added.
- R10: After reset, `out_valid` is low while `in_valid` is low, and the block is ready to forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pad_en | input | 1 | Enable padding of short frames |
| fcs_dis | input | 1 | Global suppression of the FCS for frames without pad |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte ends the frame |
| in_add_fcs | input | 1 | Per-frame FCS request, sampled with in_last |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends the frame |

## Verification
The checks assume a well-behaved upstream. It holds `in_data`, `in_last` and `in_add_fcs` while `in_valid` is high and `in_ready` is low, and it leaves `pad_en` and `fcs_dis` unchanged within a frame. The driver task respects this: it changes its byte only after a handshake, and it sets the control levels only between frames. The stall assertion also relies on this, because in the forwarding state the output byte is the input byte. `out_ready` follows a pseudo-random pattern, so stalls land on input, pad and FCS bytes alike.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  typedef enum logic [1:0] {ST_DATA = 2'd0, ST_PAD = 2'd1, ST_FCS = 2'd2} tpf_state_e;

  // Reflected CRC-32 update by one byte, one bit at a time, LSB first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB8_8320;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/tpf_crc.sv
module tpf_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        step,
  input  logic [7:0]  data,
  output logic [31:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= '1;
    else if (clear) crc <= '1;
    else if (step)  crc <= tpf_pkg::crc32_step(crc, data);
  end
endmodule

// File: rtl/tpf_len.sv
module tpf_len #(
  parameter int MIN_BODY = 60,
  localparam int CW = $clog2(MIN_BODY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic short_now,   // the current byte is not yet the minimum-th
  output logic pad_final    // the current byte is the minimum-th
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt <= '0;
    else if (clear)                            cnt <= '0;
    else if (inc && cnt != CW'(MIN_BODY))      cnt <= cnt + 1'b1;
  end

  assign short_now = cnt < CW'(MIN_BODY - 1);
  assign pad_final = cnt == CW'(MIN_BODY - 1);
endmodule

// File: rtl/tx_pad_fcs.sv
module tx_pad_fcs #(
  parameter int MIN_FRAME = 64,
  parameter int FCS_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pad_en,
  input  logic       fcs_dis,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_add_fcs,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);
  import tpf_pkg::*;

  localparam int MIN_BODY = MIN_FRAME - FCS_BYTES;
  localparam int IW = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;

  tpf_state_e     state_q, state_d;
  logic [IW-1:0]  idx_q;
  logic [31:0]    crc;
  logic           short_now, pad_final;
  logic           fire, pad_need, fcs_need, step, clear;

  assign fire = out_valid && out_ready;

  always_comb begin
    pad_need  = pad_en && short_now;
    fcs_need  = pad_need || (in_add_fcs && !fcs_dis);
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_last  = 1'b0;
    step      = 1'b0;
    clear     = 1'b0;
    state_d   = state_q;
    unique case (state_q)
      ST_DATA: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = in_last && !fcs_need;
        step      = fire;
        if (fire && in_last) begin
          if (pad_need)      state_d = ST_PAD;
          else if (fcs_need) state_d = ST_FCS;
          else               clear   = 1'b1;
        end
      end
      ST_PAD: begin
        out_valid = 1'b1;
        step      = fire;
        if (fire && pad_final) state_d = ST_FCS;
      end
      ST_FCS: begin
        out_valid = 1'b1;
        out_data  = ~crc[idx_q*8 +: 8];
        out_last  = idx_q == IW'(FCS_BYTES - 1);
        if (fire && out_last) begin
          state_d = ST_DATA;
          clear   = 1'b1;
        end
      end
      default: state_d = ST_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DATA;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_FCS) idx_q <= '0;
      else if (fire)         idx_q <= idx_q + 1'b1;
    end
  end

  tpf_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step), .data(out_data), .crc(crc)
  );

  tpf_len #(.MIN_BODY(MIN_BODY)) u_len (
    .clk(clk), .rst_n(rst_n), .clear(clear), .inc(step),
    .short_now(short_now), .pad_final(pad_final)
  );
endmodule

// File: rtl/tpf_checker.sv
module tpf_checker (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [7:0]          out_data,
  input logic                out_last,
  input tpf_pkg::tpf_state_e state
);
  import tpf_pkg::*;

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_ready_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready);

  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_PAD |-> out_valid && !in_ready && out_data == 8'h00 && !out_last);

  assert_fcs_blocks_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FCS |-> out_valid && !in_ready);

  assert_last_ends_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> state == ST_DATA);
endmodule

bind tx_pad_fcs tpf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .state(state_q)
);

// File: tb/tx_pad_fcs_bench.sv
module tx_pad_fcs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 0, rst_n = 0;
  logic pad_en = 0, fcs_dis = 0;
  logic in_valid = 0, in_last = 0, in_add_fcs = 0, out_ready = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  int checks = 0, fails = 0, cycles = 0;
  logic [8:0]  exp_q[$];     // {last, data}
  string       tag_q[$];
  logic        bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        stalled = 0;
  logic [8:0]  stall_val = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_pad_fcs u_tx_pad_fcs (
    .clk(clk), .rst_n(rst_n), .pad_en(pad_en), .fcs_dis(fcs_dis),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_add_fcs(in_add_fcs), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  // Reflected CRC-32 computed in whole-byte xor form.
  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: builds the expected output, then drives the frame.
  task automatic send_frame(input int len, input int seed, input bit pe, input bit dis,
                            input bit add, input string tag);
    logic [7:0] body[$];
    logic [31:0] c;
    bit padded, fcs;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) body.push_back(8'(seed + i * 7));
    padded = pe && len < 60;
    fcs = padded || (add && !dis);
    for (int i = 0; i < len; i++) begin
      c = ref_crc(c, body[i]);
      exp_q.push_back({(i == len - 1) && !fcs, body[i]});
      tag_q.push_back(tag);
    end
    if (padded) for (int i = len; i < 60; i++) begin
      c = ref_crc(c, 8'h00);
      exp_q.push_back({1'b0, 8'h00});
      tag_q.push_back({tag, " pad"});
    end
    if (fcs) begin
      c = ~c;
      for (int b = 0; b < 4; b++) begin
        exp_q.push_back({b == 3, c[b*8 +: 8]});
        tag_q.push_back({tag, " fcs"});
      end
    end
    pad_en  = pe;
    fcs_dis = dis;
    for (int i = 0; i < len; i++) begin
      in_valid   = 1;
      in_data    = body[i];
      in_last    = (i == len - 1);
      in_add_fcs = add;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
    end
    in_valid = 0; in_last = 0; in_add_fcs = 0;
  endtask

  // Ready pattern, driven just after the clock edge.
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= bp_mode ? lfsr[0] : 1'b1;
  end

  // Monitor: compares accepted bytes against the scoreboard; checks stall holding.
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) check(out_valid && {out_last, out_data} == stall_val,
                         "R8 hold under stall", {out_valid, out_last, out_data}, {1'b1, stall_val});
      stalled   = out_valid && !out_ready;
      stall_val = {out_last, out_data};
      check(!in_ready || out_ready, "R1 in_ready without out_ready", in_ready, 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R9 unexpected byte", {out_last, out_data}, 0);
        else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_last, out_data} == e, t, {out_last, out_data}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      check(0, "watchdog", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!out_valid, "R10 reset out_valid", out_valid, 0);
    check(in_ready, "R10 reset ready to forward", in_ready, 1);
    @(posedge clk); #1;
    send_frame(10, 8'h11, 1, 1, 0, "R5 pad forces fcs");
    send_frame(59, 8'h22, 1, 0, 0, "R2 pad one byte");
    send_frame(60, 8'h33, 1, 1, 0, "R3 no pad at 60");
    send_frame(61, 8'h44, 1, 0, 1, "R4 fcs on long frame");
    send_frame(70, 8'h55, 0, 1, 1, "R6 global disable");
    send_frame(20, 8'h66, 0, 0, 1, "R7 short no pad with fcs");
    send_frame(20, 8'h77, 0, 0, 0, "R7 short bare");
    bp_mode = 1;
    send_frame(1, 8'h88, 1, 0, 1, "R2 single byte pad");
    send_frame(45, 8'h99, 1, 1, 0, "R8 stalled pad");
    send_frame(64, 8'hAA, 1, 0, 1, "R8 stalled fcs");
    send_frame(5, 8'hBB, 0, 1, 0, "R6 no fcs stalled");
    send_frame(30, 8'hCC, 1, 0, 0, "R1 back to back");
    repeat (200) @(posedge clk);
    check(exp_q.size() == 0, "R9 all bytes delivered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule